// File: doc/BRIEF.md
# Video Unlock Security Register

This block guards a console-style system at start-up. The video engine stays switched off until software proves it knows a fixed 32-bit signature, written as two 16-bit halves into a pair of registers. A separate one-bit register moves the program memory from the internal boot ROM to the cartridge ROM. The block sits on the main processor bus. It sees the byte address with the lowest bit removed, a write qualifier, upper and lower byte strobes, and the write data. From these it drives a video-enable level and a ROM-select level.

Each signature register takes only full-word writes, where both strobes are active. The ROM-select register also accepts a lower-byte write, but it keeps only data bit 0. Decoding is exact on every address bit from 23 down to 1, so no address other than the three listed ones reaches any register. The video-enable output is refreshed on every accepted signature write. Writing anything other than the key into either half locks the video engine again. All reads return zero.

Top module: `video_unlock`

## Requirements
- R1: After reset, video_en is 0, cart_sel is 0 and both signature halves hold zero.
- R2: A word write (both strobes high) to byte address 0xA14000 stores the upper signature half. A word write to 0xA14002 stores the lower half. On the clock edge that accepts either write, video_en becomes 1 when {upper, lower} equals the KEY parameter (default 0x53454741).
- R3: A write to 0xA14000 or 0xA14002 with only one strobe active, or with none, changes no signature half and leaves video_en unchanged.
- R4: No address other than 0xA14000, 0xA14002 and 0xA14100 writes any register. Addresses that differ in any single bit from 23 down to 2 are ignored.
- R5: An accepted signature write that leaves {upper, lower} different from KEY clears video_en on that edge.
- R6: A write to 0xA14100 with the lower strobe active (word or lower byte) loads data bit 0 into cart_sel: 1 selects the cartridge ROM, 0 selects the boot ROM.
- R7: A write to 0xA14100 with only the upper strobe active, or with no strobe, leaves cart_sel unchanged.
- R8: Data bits 15 to 1 of a ROM-select write have no effect on cart_sel.
- R9: rd_data is zero at all times. A bus cycle with wr_en low changes no state.
- R10: The two signature halves may be written in either order. video_en rises only after both halves match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle qualifier |
| upper_stb | input | 1 | Upper byte strobe (data bits 15:8) |
| lower_stb | input | 1 | Lower byte strobe (data bits 7:0) |
| addr | input | 23 | Byte address bits 23:1 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, always zero |
| video_en | output | 1 | Video engine enable |
| cart_sel | output | 1 | 1 = cartridge ROM mapped, 0 = boot ROM |

## Verification
On every cycle, the assertions check four things: the three register selects are mutually exclusive, each signature half holds its value unless its own word select fires, video_en moves only on a signature write, and cart_sel moves only on a ROM-select write, loading the data bit written. Only the bench scenarios can show the rest. These are: that a correct key actually unlocks in either write order, that single-bit address neighbours are rejected, that byte writes to the signature are refused, and that bits 15 to 1 are masked. Each scenario compares the outputs against a behavioural model kept inside the bench.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_SIG_HI = 2'd1,
    SEL_SIG_LO = 2'd2,
    SEL_ROM    = 2'd3
  } reg_sel_e;

  // Strobe qualification: a full word needs both lanes.
  function automatic logic is_word(input logic ustb, input logic lstb);
    return ustb & lstb;
  endfunction

  // Lower-lane qualification: word or lower-byte access.
  function automatic logic has_low_lane(input logic lstb);
    return lstb;
  endfunction

  // Signature compare on concatenated halves.
  function automatic logic sig_matches(input logic [15:0] hi,
                                       input logic [15:0] lo,
                                       input logic [31:0] key);
    return ({hi, lo} == key);
  endfunction

endpackage

// File: rtl/unlock_decode.sv
module unlock_decode
  import unlock_pkg::*;
#(
  parameter int          ADDR_W      = 23,
  parameter logic [23:0] SIG_HI_BYTE = 24'hA14000,
  parameter logic [23:0] SIG_LO_BYTE = 24'hA14002,
  parameter logic [23:0] ROM_BYTE    = 24'hA14100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upper_stb,
  input  logic              lower_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic              hi_wr,
  output logic              lo_wr,
  output logic              rom_wr
);
  localparam logic [ADDR_W-1:0] HI_WORD  = SIG_HI_BYTE[ADDR_W:1];
  localparam logic [ADDR_W-1:0] LO_WORD  = SIG_LO_BYTE[ADDR_W:1];
  localparam logic [ADDR_W-1:0] ROM_WORD = ROM_BYTE[ADDR_W:1];

  reg_sel_e sel;

  // Full decode: every address bit compared, so nothing mirrors.
  always_comb begin
    if (addr == HI_WORD)       sel = SEL_SIG_HI;
    else if (addr == LO_WORD)  sel = SEL_SIG_LO;
    else if (addr == ROM_WORD) sel = SEL_ROM;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    hi_wr  = wr_en && (sel == SEL_SIG_HI) && is_word(upper_stb, lower_stb);
    lo_wr  = wr_en && (sel == SEL_SIG_LO) && is_word(upper_stb, lower_stb);
    rom_wr = wr_en && (sel == SEL_ROM)    && has_low_lane(lower_stb);
  end

  // R4: at most one register is selected in any cycle
  p_one_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_wr, lo_wr, rom_wr}));

endmodule

// File: rtl/unlock_sig.sv
module unlock_sig
  import unlock_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter logic [31:0] KEY    = 32'h53454741
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              video_en
);
  logic [DATA_W-1:0] sig_hi_q, sig_lo_q;
  logic [DATA_W-1:0] sig_hi_d, sig_lo_d;
  logic              sig_wr;

  always_comb begin
    sig_hi_d = hi_wr ? wr_data : sig_hi_q;
    sig_lo_d = lo_wr ? wr_data : sig_lo_q;
    sig_wr   = hi_wr | lo_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_hi_q <= '0;
      sig_lo_q <= '0;
      video_en <= 1'b0;
    end else begin
      sig_hi_q <= sig_hi_d;
      sig_lo_q <= sig_lo_d;
      if (sig_wr) video_en <= sig_matches(sig_hi_d, sig_lo_d, KEY);
    end
  end

  // R3: upper half holds unless its word select fires
  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(sig_hi_q));
  // R3: lower half holds unless its word select fires
  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> $stable(sig_lo_q));
  // R5: video enable changes only on a signature write
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_wr |=> $stable(video_en));
  // R2: an accepted upper write lands in the register
  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> sig_hi_q == $past(wr_data));

endmodule

// File: rtl/unlock_romsel.sv
module unlock_romsel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cart_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cart_sel <= 1'b0;
    else if (rom_wr) cart_sel <= wr_data[0];
  end

  // R7: ROM select holds without a qualified write
  p_rom_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_wr |=> $stable(cart_sel));
  // R6: ROM select loads data bit 0
  p_rom_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr |=> cart_sel == $past(wr_data[0]));

endmodule

// File: rtl/video_unlock.sv
module video_unlock #(
  parameter int          ADDR_W      = 23,
  parameter int          DATA_W      = 16,
  parameter logic [31:0] KEY         = 32'h53454741,
  parameter logic [23:0] SIG_HI_BYTE = 24'hA14000,
  parameter logic [23:0] SIG_LO_BYTE = 24'hA14002,
  parameter logic [23:0] ROM_BYTE    = 24'hA14100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upper_stb,
  input  logic              lower_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              video_en,
  output logic              cart_sel
);
  logic hi_wr, lo_wr, rom_wr;

  unlock_decode #(
    .ADDR_W(ADDR_W), .SIG_HI_BYTE(SIG_HI_BYTE),
    .SIG_LO_BYTE(SIG_LO_BYTE), .ROM_BYTE(ROM_BYTE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .upper_stb(upper_stb), .lower_stb(lower_stb), .addr(addr),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .rom_wr(rom_wr)
  );

  unlock_sig #(.DATA_W(DATA_W), .KEY(KEY)) u_sig (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_data(wr_data), .video_en(video_en)
  );

  unlock_romsel #(.DATA_W(DATA_W)) u_romsel (
    .clk(clk), .rst_n(rst_n), .rom_wr(rom_wr),
    .wr_data(wr_data), .cart_sel(cart_sel)
  );

  // R9: registers are write-only; reads see zero
  assign rd_data = '0;

endmodule

// File: tb/test_video_unlock.sv
module test_video_unlock;
  localparam logic [31:0] KEY = 32'h53454741;
  localparam logic [23:0] A_HI  = 24'hA14000;
  localparam logic [23:0] A_LO  = 24'hA14002;
  localparam logic [23:0] A_ROM = 24'hA14100;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, upper_stb = 0, lower_stb = 0;
  logic [22:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        video_en, cart_sel;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic [15:0] m_hi = '0, m_lo = '0;
  logic        m_cart = 0;

  always #10 clk = ~clk;

  video_unlock i_video_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .upper_stb(upper_stb),
    .lower_stb(lower_stb), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .video_en(video_en), .cart_sel(cart_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "video_en", {15'd0, video_en}, {15'd0, ({m_hi, m_lo} == KEY)});
    chk(req, "cart_sel", {15'd0, cart_sel}, {15'd0, m_cart});
    chk("R9", "rd_data", rd_data, 16'h0000);
  endtask

  // One bus cycle; model updated from the requirement text.
  task automatic bus(input logic [23:0] ba, input logic we, input logic u,
                     input logic l, input logic [15:0] d, input string req);
    @(negedge clk);
    addr = ba[23:1]; wr_en = we; upper_stb = u; lower_stb = l; wr_data = d;
    @(negedge clk);
    wr_en = 0; upper_stb = 0; lower_stb = 0;
    if (we && u && l && ba[23:1] == A_HI[23:1]) m_hi = d;
    if (we && u && l && ba[23:1] == A_LO[23:1]) m_lo = d;
    if (we && l && ba[23:1] == A_ROM[23:1]) m_cart = d[0];
    #1 check_all(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check_all("R1");

    // R3: byte writes of key to upper half refused, lower word accepted
    bus(A_HI, 1, 1, 0, KEY[31:16], "R3");
    bus(A_HI, 1, 0, 1, KEY[31:16], "R3");
    bus(A_HI, 1, 0, 0, KEY[31:16], "R3");
    bus(A_LO, 1, 1, 1, KEY[15:0], "R10");
    // R2: word upper write completes the key
    bus(A_HI, 1, 1, 1, KEY[31:16], "R2");
    // R3: byte writes after unlock keep it
    bus(A_HI, 1, 1, 0, 16'h0000, "R3");
    bus(A_LO, 1, 0, 1, 16'h0000, "R3");
    // R9: read cycles with strobes and data change nothing
    bus(A_HI, 0, 1, 1, 16'h0000, "R9");
    bus(A_ROM, 0, 1, 1, 16'h0001, "R9");
    // R5: overwrite each half
    bus(A_LO, 1, 1, 1, 16'h0000, "R5");
    bus(A_LO, 1, 1, 1, KEY[15:0], "R2");
    bus(A_HI, 1, 1, 1, KEY[31:16] ^ 16'h0100, "R5");
    // R10: halves in other order after clearing
    bus(A_LO, 1, 1, 1, 16'h1234, "R5");
    bus(A_HI, 1, 1, 1, KEY[31:16], "R10");
    bus(A_LO, 1, 1, 1, KEY[15:0], "R10");
    // R5: single-bit key corruption sweep
    for (int b = 0; b < 32; b++) begin
      logic [31:0] v;
      v = KEY ^ (32'd1 << b);
      bus(A_HI, 1, 1, 1, v[31:16], "R5");
      bus(A_LO, 1, 1, 1, v[15:0], "R5");
      bus(A_HI, 1, 1, 1, KEY[31:16], "R2");
      bus(A_LO, 1, 1, 1, KEY[15:0], "R2");
    end
    // R4: single-bit address neighbours ignored
    bus(A_LO, 1, 1, 1, 16'h0000, "R5");
    for (int k = 2; k < 24; k++) begin
      if (k != 8) begin
        bus(A_HI ^ (24'd1 << k), 1, 1, 1, KEY[31:16], "R4");
        bus(A_LO ^ (24'd1 << k), 1, 1, 1, KEY[15:0], "R4");
        bus(A_ROM ^ (24'd1 << k), 1, 1, 1, 16'h0001, "R4");
      end
    end
    // R6: exhaustive strobe sweep on ROM select
    for (int s = 0; s < 4; s++) begin
      bus(A_ROM, 1, 1, 1, 16'h0000, "R6");
      bus(A_ROM, 1, s[1], s[0], 16'h0001, s[0] ? "R6" : "R7");
      bus(A_ROM, 1, s[1], s[0], 16'h0000, s[0] ? "R6" : "R7");
    end
    // R7: upper-only write cannot clear
    bus(A_ROM, 1, 0, 1, 16'h0001, "R6");
    bus(A_ROM, 1, 1, 0, 16'h0000, "R7");
    // R8: other data bits masked
    for (int b = 1; b < 16; b++) begin
      bus(A_ROM, 1, 1, 1, 16'd1 << b, "R8");
      bus(A_ROM, 1, 0, 1, (16'd1 << b) | 16'd1, "R8");
    end
    bus(A_ROM, 1, 1, 1, 16'hFFFE, "R8");
    // R1: reset again restores defaults
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_hi = '0; m_lo = '0; m_cart = 0;
    #1 check_all("R1");
    bus(A_LO, 1, 1, 1, KEY[15:0], "R1");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule